// File: doc/BRIEF.md
# Nibble Command Detector

This block watches a stream of 4-bit hex digits that arrive one at a time from a set of switches. A pushbutton strobe marks each digit as valid. The strobe has no timing relation to the system clock, so the block first passes it through a synchronizer. It then turns each rising edge of the strobe into a single capture, and on that capture it samples the digit exactly as it appears at the input.

A small state machine tracks the most recent digits and looks for two commands. The digit A followed by the digit B is the switch-on command, and it sets a persistent LED output. The digit 5 followed by the digit 0 is the switch-off command, and it clears that output. Sequences may overlap: an A or a 5 always starts a new command attempt, whatever came before it. Each recognized command also raises a one-cycle detect pulse.

The interface is plain control pins. There is no valid/ready handshake and no back-pressure, because a switch bank and a pushbutton cannot be stalled. Each strobe rise carries exactly one digit.

Top module: `nib_cmd_top`

## Requirements
- R1: The strobe passes through a two-stage synchronizer. Each low-to-high transition of the strobe yields exactly one digit capture. Holding the strobe high, or changing the digit while the strobe stays high, captures nothing further.
- R2: The LED responds to the digit that completes a command on the third rising clock edge after the strobe goes high, provided the strobe is set up before the first of those edges. After the second edge the LED still holds its old value.
- R3: Capturing digit 4'b1010 (A) and then digit 4'b1011 (B) drives the LED to 1. The digit value is taken at its raw level, with no inversion.
- R4: Capturing digit 4'b0101 (5) and then digit 4'b0000 (0) drives the LED to 0.
- R5: A captured A always begins a new on-attempt, and a captured 5 always begins a new off-attempt, whatever the current state. For example, 5,A,B switches the LED on, A,5,0 switches it off, and A,A,B switches it on.
- R6: Any other captured digit abandons a partial command. For example, A,3,B and 5,7,0 leave the LED unchanged.
- R7: The LED holds its value between commands. A repeated on or off command leaves it unchanged.
- R8: Each recognized command, including a repeated one, produces cmd_pulse_o high for exactly one clock cycle. A digit pair that is not a command produces no pulse.
- R9: A synchronous active-high reset clears the LED and the detect pulse and returns the tracker to its idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_in | input | 1 | Asynchronous pushbutton strobe; a rising edge marks the digit as valid |
| digit_in | input | 4 | Hex digit from the switches, used at its raw level |
| led_o | output | 1 | Persistent LED state (1 = on) |
| cmd_pulse_o | output | 1 | One-cycle pulse for each recognized command |

## Verification
Every ordered pair of the 16 possible digits is sent from the idle state twice: once with the LED off and once with it already on. The first pass shows that only A,B can switch the LED on. The second shows that only 5,0 can switch it off, and that repeated commands keep the LED steady while still pulsing. Three-digit sequences then tell the restart of a sequence by A or 5 apart from the abandonment of a sequence by any other digit. A held strobe with a changing digit separates edge capture from level capture, and a cycle-exact probe pins down the latency through the synchronizer.

// File: rtl/nib_cmd_pkg.sv
package nib_cmd_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;

  localparam nib_t ON_HEAD  = 4'hA;
  localparam nib_t ON_TAIL  = 4'hB;
  localparam nib_t OFF_HEAD = 4'h5;
  localparam nib_t OFF_TAIL = 4'h0;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_ON   = 2'd1,
    TRK_OFF  = 2'd2
  } trk_state_e;
endpackage

// File: rtl/nib_strobe_edge.sv
module nib_strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic rise_o
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN-2:0], strobe_in};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R1: a capture never lasts two cycles
  assert_single_rise_R1: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/nib_cmd_tracker.sv
module nib_cmd_tracker
  import nib_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cap_i,
  input  nib_t digit_i,
  output logic led_o,
  output logic pulse_o
);
  trk_state_e state_q, state_d;
  logic       led_d, hit_on, hit_off;

  assign hit_on  = cap_i && (state_q == TRK_ON)  && (digit_i == ON_TAIL);
  assign hit_off = cap_i && (state_q == TRK_OFF) && (digit_i == OFF_TAIL);

  always_comb begin
    state_d = state_q;
    led_d   = led_o;
    if (cap_i) begin
      if (digit_i == ON_HEAD)       state_d = TRK_ON;
      else if (digit_i == OFF_HEAD) state_d = TRK_OFF;
      else                          state_d = TRK_IDLE;
      if (hit_on)  led_d = 1'b1;
      if (hit_off) led_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TRK_IDLE;
      led_o   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      state_q <= state_d;
      led_o   <= led_d;
      pulse_o <= hit_on | hit_off;
    end
  end

  assert_on_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (cap_i && state_q == TRK_ON && digit_i == ON_TAIL) |=> led_o);
  assert_off_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (cap_i && state_q == TRK_OFF && digit_i == OFF_TAIL) |=> !led_o);
  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (cap_i && digit_i == ON_HEAD) |=> state_q == TRK_ON);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> $stable(led_o));
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!led_o && !pulse_o && state_q == TRK_IDLE));
endmodule

// File: rtl/nib_cmd_top.sv
module nib_cmd_top
  import nib_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_in,
  input  logic [NIB_W-1:0] digit_in,
  output logic             led_o,
  output logic             cmd_pulse_o
);
  logic cap;

  nib_strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_in(strobe_in),
    .rise_o   (cap)
  );

  nib_cmd_tracker u_trk (
    .clk    (clk),
    .rst    (rst),
    .cap_i  (cap),
    .digit_i(digit_in),
    .led_o  (led_o),
    .pulse_o(cmd_pulse_o)
  );
endmodule

// File: tb/sim_nib_cmd_top.sv
module sim_nib_cmd_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_in = 1'b0;
  logic [3:0] digit_in = 4'h0;
  logic       led_o, cmd_pulse_o;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int max_run = 0;
  int run = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nib_cmd_top u0 (
    .clk(clk), .rst(rst), .strobe_in(strobe_in), .digit_in(digit_in),
    .led_o(led_o), .cmd_pulse_o(cmd_pulse_o)
  );

  always @(negedge clk) begin
    if (cmd_pulse_o) begin
      pulses++;
      run++;
      if (run > max_run) max_run = run;
    end else begin
      run = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    strobe_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [3:0] d);
    @(negedge clk);
    digit_in = d;
    strobe_in = 1'b1;
    repeat (5) @(negedge clk);
    strobe_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic bit is_cmd_on(input logic [3:0] a, input logic [3:0] b);
    return (a == 4'hA) && (b == 4'hB);
  endfunction

  function automatic bit is_cmd_off(input logic [3:0] a, input logic [3:0] b);
    return (a == 4'h5) && (b == 4'h0);
  endfunction

  task automatic seq3(input string req, input logic [3:0] a, input logic [3:0] b,
                      input logic [3:0] c, input bit start_on, input int exp_led);
    do_reset();
    if (start_on) begin send(4'hA); send(4'hB); end
    send(a); send(b); send(c);
    check(req, led_o, exp_led);
  endtask

  initial begin
    int p0;
    do_reset();
    check("R9 led after reset", led_o, 0);
    check("R9 pulse after reset", cmd_pulse_o, 0);

    // R3 R4 R8: sweep of every digit pair, LED initially off
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_reset();
        p0 = pulses;
        send(4'(a)); send(4'(b));
        check("R3 pair from off", led_o, is_cmd_on(4'(a), 4'(b)));
        check("R8 pulses from off", pulses - p0,
              (is_cmd_on(4'(a), 4'(b)) || is_cmd_off(4'(a), 4'(b))) ? 1 : 0);
      end
    end

    // R4 R7 R8: sweep of every digit pair, LED initially on
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_reset();
        send(4'hA); send(4'hB);
        p0 = pulses;
        send(4'(a)); send(4'(b));
        check("R4 R7 pair from on", led_o, is_cmd_off(4'(a), 4'(b)) ? 0 : 1);
        check("R8 pulses from on", pulses - p0,
              (is_cmd_on(4'(a), 4'(b)) || is_cmd_off(4'(a), 4'(b))) ? 1 : 0);
      end
    end
    check("R8 pulse width", max_run, 1);

    // R5: overlapping sequences
    seq3("R5 5,A,B", 4'h5, 4'hA, 4'hB, 1'b0, 1);
    seq3("R5 A,5,0", 4'hA, 4'h5, 4'h0, 1'b1, 0);
    seq3("R5 A,A,B", 4'hA, 4'hA, 4'hB, 1'b0, 1);
    seq3("R5 5,5,0", 4'h5, 4'h5, 4'h0, 1'b1, 0);
    // R6: abandoned sequences
    seq3("R6 A,3,B", 4'hA, 4'h3, 4'hB, 1'b0, 0);
    seq3("R6 5,7,0", 4'h5, 4'h7, 4'h0, 1'b1, 1);
    seq3("R6 A,0,B", 4'hA, 4'h0, 4'hB, 1'b0, 0);

    // R1: held strobe captures once; a digit change while high is ignored
    do_reset();
    send(4'hA);
    @(negedge clk);
    digit_in = 4'h3;
    strobe_in = 1'b1;
    repeat (5) @(negedge clk);
    digit_in = 4'hB;
    repeat (6) @(negedge clk);
    check("R1 change while held", led_o, 0);
    strobe_in = 1'b0;
    repeat (4) @(negedge clk);
    do_reset();
    send(4'hA);
    @(negedge clk);
    digit_in = 4'hB;
    strobe_in = 1'b1;
    repeat (5) @(negedge clk);
    digit_in = 4'h5;
    repeat (6) @(negedge clk);
    check("R1 single capture on", led_o, 1);
    strobe_in = 1'b0;
    repeat (4) @(negedge clk);

    // R2: cycle-exact latency
    do_reset();
    send(4'hA);
    @(negedge clk);
    digit_in = 4'hB;
    strobe_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 after second edge", led_o, 0);
    @(negedge clk);
    check("R2 after third edge", led_o, 1);
    strobe_in = 1'b0;
    repeat (4) @(negedge clk);

    // R9: reset clears a lit LED
    do_reset();
    check("R9 reset clears led", led_o, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule